// File: doc/BRIEF.md
# Partition Policy Register File

This block keeps the resource-control settings for every partition served by one memory-system component. Each partition has three settings: a mask of the cache portions it may allocate into, a cap on its bandwidth given as a fraction of full scale, and a mask of the bandwidth portions it may use. Software cannot address these settings directly. It first writes a partition number into a select register. Every later access to a policy register then reads or writes that partition's entry. An identification register reports the number of partitions and which of the three settings are built in.

Traffic entering the component carries a partition tag. A lookup port takes the tag and returns that partition's three settings to the enforcement logic downstream, with no clock cycle in between. After reset every partition is unrestricted: both masks are all ones and the cap is at full scale. The register port is a 32-bit valid/ready port whose ready is always high. Each request gets a one-cycle response that carries read data and an error bit.

Top module: `ppr_partition_policy`

## Requirements
- R1: After a synchronous active-low reset, every partition has both masks at all ones and the bandwidth cap at full scale (all ones, 0x7F at the default width). The select register also reads 0.
- R2: Offset 0x00 is the select register. A write stores the low PART_W bits of the data as the selected partition. A read returns the stored partition in bits [PART_W-1:0] and an out-of-range flag in bit 31.
- R3: Offset 0x08 holds the cache portion mask (low CPORT_W bits), 0x0C the bandwidth cap (low BWMAX_W bits) and 0x10 the bandwidth portion mask (low BPORT_W bits). Reads and writes at these offsets act on the selected partition's entry, and unused upper bits read as zero.
- R4: A policy write changes only the selected partition's entry for that one setting. Every other partition and every other setting keeps its value.
- R5: Offset 0x04 is a read-only identification word. Bits [15:0] hold NUM_PARTS-1, and bits 16, 17 and 18 flag that the cache mask, the bandwidth cap and the bandwidth mask are present. A write to this offset is ignored and gives no error.
- R6: When a setting is not built in, its register reads as zero, writes to it are ignored without error, and the lookup port returns all ones for it.
- R7: A select write whose full 32-bit value is NUM_PARTS or more sets the out-of-range flag. While the flag is set, every policy register access returns data 0 with the error bit set, and policy writes change no entry.
- R8: An access to any offset other than 0x00, 0x04, 0x08, 0x0C or 0x10 returns data 0 with the error bit set and has no effect.
- R9: Each request accepted with req_valid high produces exactly one response, with rsp_valid high in the next cycle. rsp_valid is low in the cycle after a cycle with no request. Writes return data 0.
- R10: The lookup outputs follow lk_part combinationally. A policy write shows up on the lookup port in the cycle after the write is accepted. In the cycle of the write itself, a lookup of the same partition returns the old value.
- R11: A lookup tag of NUM_PARTS or more returns the unrestricted policy: all ones on all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access error (out-of-range select or unmapped offset) |
| lk_part | input | PART_W | Partition tag of incoming traffic |
| lk_cpbm | output | CPORT_W | Cache portion mask for lk_part |
| lk_bwmax | output | BWMAX_W | Bandwidth cap for lk_part |
| lk_bwpbm | output | BPORT_W | Bandwidth portion mask for lk_part |

## Verification
Two functions can act on the same partition in the same cycle: a policy write accepted on the register port, and a lookup of that partition on the traffic side. The bench provokes this by driving the write and the matching lk_part together. It expects the old mask while the write is pending and the new mask one cycle later. Back-to-back register requests with no idle cycle between them check that response order and timing hold when the port is busy every cycle.

// File: rtl/ppr_pkg.sv
// Package: ppr_pkg
// Holds the register offsets and the decoded register kind shared by the
// partition policy register file. It assumes 32-bit registers on a byte-addressed port.
package ppr_pkg;

    localparam logic [7:0] OFF_SEL   = 8'h00;
    localparam logic [7:0] OFF_ID    = 8'h04;
    localparam logic [7:0] OFF_CPBM  = 8'h08;
    localparam logic [7:0] OFF_BWMAX = 8'h0C;
    localparam logic [7:0] OFF_BWPBM = 8'h10;

    // Which register a request targets after decode
    typedef enum logic [2:0] {
        RK_SEL,
        RK_ID,
        RK_CPBM,
        RK_BWMAX,
        RK_BWPBM,
        RK_NONE
    } reg_kind_e;

endpackage

// File: rtl/ppr_field_store.sv
// Module: ppr_field_store
// Stores one policy setting for every partition. It has one write port, one
// read port for the register side and one lookup port for traffic. All
// entries reset to all ones, the unrestricted value. When PRESENT is 0 the
// setting is not built in: reads return zero and lookups return all ones.
// Assumes the caller qualifies wr_en. The index range is checked again here.
module ppr_field_store #(
    parameter int  W       = 8,
    parameter int  DEPTH   = 12,
    parameter int  IDX_W   = 4,
    parameter bit  PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [W-1:0]     lk_data
);

    localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

    logic wr_in_range;
    logic rd_in_range;
    logic lk_in_range;

    // Range checks on every index that reaches the table
    always_comb begin
        wr_in_range = ({1'b0, wr_idx} < DEPTH_V);
        rd_in_range = ({1'b0, rd_idx} < DEPTH_V);
        lk_in_range = ({1'b0, lk_idx} < DEPTH_V);
    end

    generate
        if (PRESENT) begin : g_present
            logic [DEPTH-1:0][W-1:0] mem;

            // Table update: reset to unrestricted, else write the addressed entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem <= '1;
                end else if (wr_en && wr_in_range) begin
                    mem[wr_idx] <= wr_data;
                end
            end

            // Read and lookup muxes
            always_comb begin
                rd_data = rd_in_range ? mem[rd_idx] : '0;
                lk_data = lk_in_range ? mem[lk_idx] : '1;
            end

            AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_in_range) |=> (mem[$past(wr_idx)] == $past(wr_data))); // R3

            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(mem)); // R4
        end else begin : g_absent
            logic unused_inputs;

            // Setting not built in: fixed outputs
            always_comb begin
                rd_data = '0;
                lk_data = '1;
            end

            assign unused_inputs = ^{clk, rst_n, wr_en, wr_idx, wr_data,
                                     rd_in_range, lk_in_range, wr_in_range};
        end
    endgenerate

endmodule

// File: rtl/ppr_regif.sv
// Module: ppr_regif
// Register-side front end. It decodes the offset, holds the partition select
// register and its out-of-range flag, qualifies the policy write strobes,
// multiplexes read data and registers the one-cycle response. The port always
// accepts, so req_ready is tied high.
module ppr_regif
    import ppr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PART_W    = 4,
    parameter int NUM_PARTS = 12,
    parameter int CPORT_W   = 8,
    parameter int BWMAX_W   = 7,
    parameter int BPORT_W   = 8,
    parameter bit HAS_CPBM  = 1'b1,
    parameter bit HAS_BWMAX = 1'b1,
    parameter bit HAS_BWPBM = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               rsp_err,
    output logic [PART_W-1:0]  sel_idx,
    output logic               wr_cpbm,
    output logic               wr_bwmax,
    output logic               wr_bwpbm,
    input  logic [CPORT_W-1:0] rd_cpbm,
    input  logic [BWMAX_W-1:0] rd_bwmax,
    input  logic [BPORT_W-1:0] rd_bwpbm
);

    localparam logic [31:0] ID_WORD = {13'd0, HAS_BWPBM, HAS_BWMAX, HAS_CPBM,
                                       16'(NUM_PARTS - 1)};
    localparam logic [31:0] LIMIT   = 32'(NUM_PARTS);

    reg_kind_e         kind;
    logic              is_policy;
    logic              sel_bad_q;
    logic [PART_W-1:0] sel_q;
    logic [31:0]       rdata_d;
    logic              err_d;
    logic              do_wr;

    assign req_ready = 1'b1;
    assign sel_idx   = sel_q;
    assign do_wr     = req_valid && req_write;

    // Offset decode
    always_comb begin
        case (req_addr)
            ADDR_W'(OFF_SEL):   kind = RK_SEL;
            ADDR_W'(OFF_ID):    kind = RK_ID;
            ADDR_W'(OFF_CPBM):  kind = RK_CPBM;
            ADDR_W'(OFF_BWMAX): kind = RK_BWMAX;
            ADDR_W'(OFF_BWPBM): kind = RK_BWPBM;
            default:            kind = RK_NONE;
        endcase
        is_policy = (kind == RK_CPBM) || (kind == RK_BWMAX) || (kind == RK_BWPBM);
    end

    // Select register and its out-of-range flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            sel_bad_q <= 1'b0;
        end else if (do_wr && kind == RK_SEL) begin
            sel_q     <= req_wdata[PART_W-1:0];
            sel_bad_q <= (req_wdata >= LIMIT);
        end
    end

    // Policy write strobes, blocked while the select is out of range
    always_comb begin
        wr_cpbm  = do_wr && !sel_bad_q && HAS_CPBM  && (kind == RK_CPBM);
        wr_bwmax = do_wr && !sel_bad_q && HAS_BWMAX && (kind == RK_BWMAX);
        wr_bwpbm = do_wr && !sel_bad_q && HAS_BWPBM && (kind == RK_BWPBM);
    end

    // Read data and error for the current request
    always_comb begin
        rdata_d = '0;
        err_d   = 1'b0;
        case (kind)
            RK_SEL:   rdata_d = {sel_bad_q, {(31-PART_W){1'b0}}, sel_q};
            RK_ID:    rdata_d = ID_WORD;
            RK_CPBM:  rdata_d = (sel_bad_q || !HAS_CPBM)  ? '0 : 32'(rd_cpbm);
            RK_BWMAX: rdata_d = (sel_bad_q || !HAS_BWMAX) ? '0 : 32'(rd_bwmax);
            RK_BWPBM: rdata_d = (sel_bad_q || !HAS_BWPBM) ? '0 : 32'(rd_bwpbm);
            default:  err_d   = 1'b1;
        endcase
        if (is_policy && sel_bad_q) begin
            err_d = 1'b1;
        end
    end

    // Response register, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rdata_d : '0;
            rsp_err   <= req_valid ? err_d : 1'b0;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9

    AST_BAD_SEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_policy && sel_bad_q) |=> (rsp_err && rsp_rdata == 32'd0)); // R7

    AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == RK_NONE) |=> (rsp_err && rsp_rdata == 32'd0)); // R8

    AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |=> (rsp_rdata == 32'd0)); // R9

endmodule

// File: rtl/ppr_partition_policy.sv
// Module: ppr_partition_policy
// Top of the partition policy register file. The register front end drives
// three per-setting tables: the cache portion mask, the bandwidth cap and the
// bandwidth portion mask. A combinational lookup port returns one partition's
// settings to the enforcement logic. Assumes PART_W <= 16 and
// NUM_PARTS <= 2**PART_W.
module ppr_partition_policy #(
    parameter int ADDR_W    = 8,
    parameter int PART_W    = 4,
    parameter int NUM_PARTS = 12,
    parameter int CPORT_W   = 8,
    parameter int BWMAX_W   = 7,
    parameter int BPORT_W   = 8,
    parameter bit HAS_CPBM  = 1'b1,
    parameter bit HAS_BWMAX = 1'b1,
    parameter bit HAS_BWPBM = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               rsp_err,
    input  logic [PART_W-1:0]  lk_part,
    output logic [CPORT_W-1:0] lk_cpbm,
    output logic [BWMAX_W-1:0] lk_bwmax,
    output logic [BPORT_W-1:0] lk_bwpbm
);

    logic [PART_W-1:0]  sel_idx;
    logic               wr_cpbm;
    logic               wr_bwmax;
    logic               wr_bwpbm;
    logic [CPORT_W-1:0] rd_cpbm;
    logic [BWMAX_W-1:0] rd_bwmax;
    logic [BPORT_W-1:0] rd_bwpbm;

    ppr_regif #(
        .ADDR_W(ADDR_W), .PART_W(PART_W), .NUM_PARTS(NUM_PARTS),
        .CPORT_W(CPORT_W), .BWMAX_W(BWMAX_W), .BPORT_W(BPORT_W),
        .HAS_CPBM(HAS_CPBM), .HAS_BWMAX(HAS_BWMAX), .HAS_BWPBM(HAS_BWPBM)
    ) u_regif (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .sel_idx(sel_idx),
        .wr_cpbm(wr_cpbm), .wr_bwmax(wr_bwmax), .wr_bwpbm(wr_bwpbm),
        .rd_cpbm(rd_cpbm), .rd_bwmax(rd_bwmax), .rd_bwpbm(rd_bwpbm)
    );

    ppr_field_store #(
        .W(CPORT_W), .DEPTH(NUM_PARTS), .IDX_W(PART_W), .PRESENT(HAS_CPBM)
    ) u_cpbm (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_cpbm), .wr_idx(sel_idx), .wr_data(req_wdata[CPORT_W-1:0]),
        .rd_idx(sel_idx), .rd_data(rd_cpbm),
        .lk_idx(lk_part), .lk_data(lk_cpbm)
    );

    ppr_field_store #(
        .W(BWMAX_W), .DEPTH(NUM_PARTS), .IDX_W(PART_W), .PRESENT(HAS_BWMAX)
    ) u_bwmax (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_bwmax), .wr_idx(sel_idx), .wr_data(req_wdata[BWMAX_W-1:0]),
        .rd_idx(sel_idx), .rd_data(rd_bwmax),
        .lk_idx(lk_part), .lk_data(lk_bwmax)
    );

    ppr_field_store #(
        .W(BPORT_W), .DEPTH(NUM_PARTS), .IDX_W(PART_W), .PRESENT(HAS_BWPBM)
    ) u_bwpbm (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_bwpbm), .wr_idx(sel_idx), .wr_data(req_wdata[BPORT_W-1:0]),
        .rd_idx(sel_idx), .rd_data(rd_bwpbm),
        .lk_idx(lk_part), .lk_data(lk_bwpbm)
    );

    AST_ONE_WRITE_PER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_cpbm, wr_bwmax, wr_bwpbm}) <= 1); // R4

    AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cpbm || wr_bwmax || wr_bwpbm) |-> (req_valid && req_write)); // R4

endmodule

// File: tb/tb_ppr_partition_policy.sv
`timescale 1ns/1ps
module tb_ppr_partition_policy;

    typedef struct {
        logic [31:0] data;
        logic        err;
        int          cyc;
        string       rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  lk_part = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [7:0]  lk_cpbm, lk_bwpbm;
    logic [6:0]  lk_bwmax;
    logic        req_ready2, rsp_valid2, rsp_err2;
    logic [31:0] rsp_rdata2;
    logic [7:0]  lk_cpbm2, lk_bwpbm2;
    logic [6:0]  lk_bwmax2;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    bit   done    = 1'b0;
    exp_t sb[$];
    logic [31:0] r2_data;
    logic        r2_err;

    always #4 clk = ~clk;

    ppr_partition_policy dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .lk_part(lk_part), .lk_cpbm(lk_cpbm), .lk_bwmax(lk_bwmax), .lk_bwpbm(lk_bwpbm)
    );

    ppr_partition_policy #(.HAS_BWPBM(1'b0)) dut2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready2),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid2), .rsp_rdata(rsp_rdata2), .rsp_err(rsp_err2),
        .lk_part(lk_part), .lk_cpbm(lk_cpbm2), .lk_bwmax(lk_bwmax2), .lk_bwpbm(lk_bwpbm2)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.rq, " data"}, rsp_rdata, e.data);
                chk({e.rq, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
                chk("R9 latency", 32'(cyc), 32'(e.cyc + 1));
            end
        end
    end

    // Driver: place a request and queue its expected response
    task automatic bus_issue(bit wr, logic [7:0] a, logic [31:0] d,
                             logic [31:0] ed, bit ee, string rq);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        e.data = ed; e.err = ee; e.cyc = cyc; e.rq = rq;
        sb.push_back(e);
    endtask

    task automatic bus_idle();
        @(negedge clk);
        r2_data   = rsp_rdata2;
        r2_err    = rsp_err2;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic bus(bit wr, logic [7:0] a, logic [31:0] d,
                       logic [31:0] ed, bit ee, string rq);
        bus_issue(wr, a, d, ed, ee, rq);
        bus_idle();
    endtask

    task automatic lk_chk(logic [3:0] p, logic [7:0] c, logic [6:0] m,
                          logic [7:0] b, string rq);
        lk_part = p;
        #1;
        chk({rq, " lk_cpbm"}, 32'(lk_cpbm), 32'(c));
        chk({rq, " lk_bwmax"}, 32'(lk_bwmax), 32'(m));
        chk({rq, " lk_bwpbm"}, 32'(lk_bwpbm), 32'(b));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {31'd0, rsp_valid}, 32'd0);
        // R1: all partitions unrestricted after reset
        for (int p = 0; p < 12; p++) lk_chk(4'(p), 8'hFF, 7'h7F, 8'hFF, "R1");
        bus(1'b0, 8'h00, 0, 32'h0, 1'b0, "R1 select reset");
        bus(1'b0, 8'h08, 0, 32'hFF, 1'b0, "R1 cpbm reset");
        bus(1'b0, 8'h0C, 0, 32'h7F, 1'b0, "R1 bwmax reset");

        // R5: identification word, read-only
        bus(1'b0, 8'h04, 0, 32'h0007000B, 1'b0, "R5 id");
        chk("R6 id of reduced build", r2_data, 32'h0003000B);
        bus(1'b1, 8'h04, 32'h12345678, 32'h0, 1'b0, "R5 id write");
        bus(1'b0, 8'h04, 0, 32'h0007000B, 1'b0, "R5 id after write");

        // R2, R3: select partition 5 and program it
        bus(1'b1, 8'h00, 32'd5, 32'h0, 1'b0, "R2 select write");
        bus(1'b0, 8'h00, 0, 32'd5, 1'b0, "R2 select read");
        bus(1'b1, 8'h08, 32'hFFFFFF3C, 32'h0, 1'b0, "R3 cpbm write");
        bus(1'b0, 8'h08, 0, 32'h3C, 1'b0, "R3 cpbm read");
        bus(1'b1, 8'h0C, 32'h40, 32'h0, 1'b0, "R3 bwmax write");
        bus(1'b0, 8'h0C, 0, 32'h40, 1'b0, "R3 bwmax read");
        bus(1'b1, 8'h10, 32'h0F, 32'h0, 1'b0, "R3 bwpbm write");
        chk("R6 absent write data", r2_data, 32'h0);
        chk("R6 absent write err", {31'd0, r2_err}, 32'd0);
        bus(1'b0, 8'h10, 0, 32'h0F, 1'b0, "R3 bwpbm read");
        chk("R6 absent read data", r2_data, 32'h0);
        chk("R6 absent read err", {31'd0, r2_err}, 32'd0);
        lk_chk(4'd5, 8'h3C, 7'h40, 8'h0F, "R3");
        chk("R6 absent lookup", 32'(lk_bwpbm2), 32'hFF);
        chk("R6 present lookup", 32'(lk_cpbm2), 32'h3C);

        // R4: another partition's write leaves the others alone
        bus(1'b1, 8'h00, 32'd6, 32'h0, 1'b0, "R4 select");
        bus(1'b1, 8'h08, 32'hA5, 32'h0, 1'b0, "R4 cpbm write");
        lk_chk(4'd6, 8'hA5, 7'h7F, 8'hFF, "R4 target");
        lk_chk(4'd5, 8'h3C, 7'h40, 8'h0F, "R4 neighbour");
        lk_chk(4'd7, 8'hFF, 7'h7F, 8'hFF, "R4 untouched");

        // R7: select out of range
        bus(1'b1, 8'h00, 32'd12, 32'h0, 1'b0, "R7 select 12");
        bus(1'b0, 8'h00, 0, 32'h8000000C, 1'b0, "R7 flag read");
        bus(1'b0, 8'h08, 0, 32'h0, 1'b1, "R7 cpbm read");
        bus(1'b1, 8'h08, 32'h00, 32'h0, 1'b1, "R7 cpbm write");
        bus(1'b1, 8'h00, 32'd100, 32'h0, 1'b0, "R7 select 100");
        bus(1'b0, 8'h00, 0, 32'h80000004, 1'b0, "R7 flag read 100");
        bus(1'b1, 8'h0C, 32'h01, 32'h0, 1'b1, "R7 bwmax write");
        bus(1'b1, 8'h00, 32'd4, 32'h0, 1'b0, "R7 select 4");
        bus(1'b0, 8'h0C, 0, 32'h7F, 1'b0, "R7 alias untouched");
        lk_chk(4'd4, 8'hFF, 7'h7F, 8'hFF, "R7 lookup");

        // R8: unmapped offsets
        bus(1'b0, 8'h14, 0, 32'h0, 1'b1, "R8 read 0x14");
        bus(1'b0, 8'h02, 0, 32'h0, 1'b1, "R8 read 0x02");
        bus(1'b1, 8'h20, 32'h0, 32'h0, 1'b1, "R8 write 0x20");
        bus(1'b0, 8'h0C, 0, 32'h7F, 1'b0, "R8 no side effect");

        // R9: back-to-back requests
        bus_issue(1'b1, 8'h00, 32'd5, 32'h0, 1'b0, "R9 b2b sel");
        bus_issue(1'b0, 8'h08, 0, 32'h3C, 1'b0, "R9 b2b cpbm");
        bus_issue(1'b0, 8'h0C, 0, 32'h40, 1'b0, "R9 b2b bwmax");
        bus_issue(1'b0, 8'h04, 0, 32'h0007000B, 1'b0, "R9 b2b id");
        bus_idle();

        // R10: write and lookup of the same partition in one cycle
        bus(1'b1, 8'h00, 32'd9, 32'h0, 1'b0, "R10 select");
        bus_issue(1'b1, 8'h08, 32'h11, 32'h0, 1'b0, "R10 write");
        lk_part = 4'd9;
        #1;
        chk("R10 old value in write cycle", 32'(lk_cpbm), 32'hFF);
        bus_idle();
        #1;
        chk("R10 new value next cycle", 32'(lk_cpbm), 32'h11);

        // R11: tags past the partition count
        for (int p = 12; p < 16; p++) lk_chk(4'(p), 8'hFF, 7'h7F, 8'hFF, "R11");

        @(negedge clk);
        @(negedge clk);
        chk("R9 all responses seen", 32'(sb.size()), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule